// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block walks a chain of two-word transmit descriptors in memory and turns the buffers they point at into a byte stream for an Ethernet MAC. Software places descriptors at a queue base address and writes a start command with the transmit enable set. The engine then reads each descriptor: word 0 holds the byte address of a buffer, and word 1 holds the buffer length and the ownership and chaining flags. It fetches the buffer a word at a time and hands the bytes out one per accepted beat.

A frame may span several descriptors. When the buffer flagged as the frame's last one has gone out, the engine writes word 1 of the frame's first descriptor back with the used flag set, which returns the frame to software, and it raises a sticky done flag. It then moves on to the next descriptor. The engine halts as soon as it reads a descriptor that software has not handed over (used flag already set). If this happens part way through a frame, the write-back also carries an exhaustion flag. A read error on buffer data is recorded as an underrun flag in the same write-back.

Top module: `txd_fetch_engine`

## Requirements
- R1: After reset, busy_o and done_o are 0, and there is no memory request and no valid output byte; while busy_o is 0 the engine issues no memory request and no byte.
- R2: A command write (cmd_we_i) with cmd_start_i=1 and cmd_txen_i=1 starts the engine at qbase_i: word 0 is read at qbase_i and word 1 at qbase_i+4. A command write with cmd_txen_i=0 starts nothing.
- R3: Word 0 is the buffer byte address. Word 1 carries the length in bits 10:0, the last-buffer flag in bit 15, the wrap flag in bit 30 and the used flag in bit 31.
- R4: Buffer bytes are streamed in ascending address order from any byte alignment. The byte at an address with low bits k lies in bits 8k+7:8k of its word. A length of 0 emits nothing. tx_eof_o is 1 only on the final byte of a buffer flagged last.
- R5: While tx_valid_o is 1 and tx_ready_i is 0, tx_valid_o, tx_data_o and tx_eof_o hold.
- R6: A memory request holds its address, direction and write data until mem_ack_i.
- R7: The next descriptor is at the current address plus 8, or at qbase_i when the current descriptor has the wrap flag.
- R8: After the last buffer of a frame, word 1 of the frame's first descriptor is written back with bit 31 set and its other bits unchanged. done_o is then set, and the engine goes on to the next descriptor.
- R9: A used descriptor met at a frame boundary stops the engine (busy_o to 0) with no write-back and no change to done_o.
- R10: A used descriptor met inside a frame ends it: the first descriptor's word 1 is written back with bits 31 and 27 set, done_o is set, and the engine stops.
- R11: A buffer read answered with mem_err_i=1 sets bit 28 in the frame's write-back.
- R12: A start command while busy_o is 1 is ignored: the byte stream and the write-backs are the same as without it.
- R13: A stat_clr_i pulse clears done_o; done_o otherwise stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_start_i | input | 1 | Start request carried by the command write |
| cmd_txen_i | input | 1 | Transmit enable carried by the command write |
| stat_clr_i | input | 1 | Write-one pulse that clears done |
| qbase_i | input | AW | Queue base byte address |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Request completed |
| mem_err_i | input | 1 | Read completed with an error |
| tx_valid_o | output | 1 | Output byte valid |
| tx_data_o | output | 8 | Output byte |
| tx_eof_o | output | 1 | Byte ends the frame |
| tx_ready_i | input | 1 | Sink accepts the byte |
| done_o | output | 1 | Sticky frame-done flag |
| busy_o | output | 1 | Engine running |

## Verification
The hardest situation to reach is an exhausted frame, where a handed-over descriptor is followed by one still owned by software before any last flag. The bench builds that chain directly in its memory model. A nearby case is the wrap back to a base descriptor that the engine itself has just written back. The bench places a valid decoy descriptor past the wrapping one, so that a wrong wrap would show up as extra bytes. A near-exhaustive sweep covers lengths, byte offsets, memory latencies and sink stall patterns, and a start pulse injected mid-frame exercises the busy case.

// File: rtl/txd_pkg.sv
package txd_pkg;
   localparam int LEN_W      = 11;
   localparam int LAST_BIT   = 15;
   localparam int EXH_BIT    = 27;
   localparam int UND_BIT    = 28;
   localparam int WRAP_BIT   = 30;
   localparam int USED_BIT   = 31;
   localparam int WORD_W     = 32;
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int DESC_BYTES = 2 * WORD_BYTES;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH0,
      S_FETCH1,
      S_LOAD,
      S_EMIT,
      S_ADV,
      S_RETIRE
   } seq_st_e;
endpackage

// File: rtl/txd_desc_step.sv
module txd_desc_step
   import txd_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic [AW-1:0] cur_i,
   input  logic [AW-1:0] base_i,
   input  logic          wrap_i,
   output logic [AW-1:0] next_o
);
   localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

   always_comb begin
      next_o = wrap_i ? base_i : (cur_i + STEP);
   end
endmodule

// File: rtl/txd_lane_pick.sv
module txd_lane_pick #(
   parameter int DW = 32
) (
   input  logic [DW-1:0]                  word_i,
   input  logic [$clog2(DW/8)-1:0]        sel_i,
   output logic [7:0]                     byte_o
);
   localparam int LANES = DW / 8;

   logic [7:0] lane_w [LANES];

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign lane_w[k] = word_i[8*k +: 8];
      end
   endgenerate

   assign byte_o = lane_w[sel_i];
endmodule

// File: rtl/txd_status.sv
module txd_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic done_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o <= 1'b0;
      end else if (set_i) begin
         done_o <= 1'b1;
      end else if (clr_i) begin
         done_o <= 1'b0;
      end
   end
endmodule

// File: rtl/txd_seq.sv
module txd_seq
   import txd_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [AW-1:0]     qbase_i,
   input  logic [AW-1:0]     next_desc_i,
   input  logic              mem_ack_i,
   input  logic [WORD_W-1:0] mem_rdata_i,
   input  logic              mem_err_i,
   input  logic              tx_ready_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [AW-1:0]     mem_addr_o,
   output logic [WORD_W-1:0] mem_wdata_o,
   output logic              tx_valid_o,
   output logic              tx_eof_o,
   output logic [WORD_W-1:0] word_o,
   output logic [1:0]        lane_o,
   output logic [AW-1:0]     desc_addr_o,
   output logic              wrap_o,
   output logic              busy_o,
   output logic              retire_o
);
   localparam logic [AW-1:0]    W1_OFS = AW'(WORD_BYTES);
   localparam logic [LEN_W-1:0] ONE    = LEN_W'(1);

   seq_st_e            state_q;
   logic [AW-1:0]      desc_q;
   logic [AW-1:0]      first_q;
   logic [WORD_W-1:0]  first_stat_q;
   logic [AW-1:0]      buf_q;
   logic [LEN_W-1:0]   rem_q;
   logic [WORD_W-1:0]  word_q;
   logic               last_q;
   logic               wrap_q;
   logic               in_frame_q;
   logic               exh_q;
   logic               und_q;
   logic               halt_q;

   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = '0;
      mem_wdata_o = '0;
      unique case (state_q)
         S_FETCH0: begin
            mem_req_o  = 1'b1;
            mem_addr_o = desc_q;
         end
         S_FETCH1: begin
            mem_req_o  = 1'b1;
            mem_addr_o = desc_q + W1_OFS;
         end
         S_LOAD: begin
            mem_req_o  = 1'b1;
            mem_addr_o = {buf_q[AW-1:2], 2'b00};
         end
         S_RETIRE: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = first_q + W1_OFS;
            mem_wdata_o = first_stat_q;
            mem_wdata_o[USED_BIT] = 1'b1;
            if (exh_q) mem_wdata_o[EXH_BIT] = 1'b1;
            if (und_q) mem_wdata_o[UND_BIT] = 1'b1;
         end
         default: ;
      endcase
   end

   assign tx_valid_o  = (state_q == S_EMIT);
   assign tx_eof_o    = (state_q == S_EMIT) && last_q && (rem_q == ONE);
   assign word_o      = word_q;
   assign lane_o      = buf_q[1:0];
   assign desc_addr_o = desc_q;
   assign wrap_o      = wrap_q;
   assign busy_o      = (state_q != S_IDLE);
   assign retire_o    = (state_q == S_RETIRE) && mem_ack_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= S_IDLE;
         desc_q       <= '0;
         first_q      <= '0;
         first_stat_q <= '0;
         buf_q        <= '0;
         rem_q        <= '0;
         word_q       <= '0;
         last_q       <= 1'b0;
         wrap_q       <= 1'b0;
         in_frame_q   <= 1'b0;
         exh_q        <= 1'b0;
         und_q        <= 1'b0;
         halt_q       <= 1'b0;
      end else begin
         unique case (state_q)
            S_IDLE: begin
               if (go_i) begin
                  desc_q     <= qbase_i;
                  in_frame_q <= 1'b0;
                  exh_q      <= 1'b0;
                  und_q      <= 1'b0;
                  halt_q     <= 1'b0;
                  state_q    <= S_FETCH0;
               end
            end
            S_FETCH0: begin
               if (mem_ack_i) begin
                  buf_q   <= mem_rdata_i[AW-1:0];
                  state_q <= S_FETCH1;
               end
            end
            S_FETCH1: begin
               if (mem_ack_i) begin
                  if (mem_rdata_i[USED_BIT]) begin
                     if (in_frame_q) begin
                        exh_q   <= 1'b1;
                        halt_q  <= 1'b1;
                        state_q <= S_RETIRE;
                     end else begin
                        state_q <= S_IDLE;
                     end
                  end else begin
                     if (!in_frame_q) begin
                        first_q      <= desc_q;
                        first_stat_q <= mem_rdata_i;
                        in_frame_q   <= 1'b1;
                     end
                     rem_q   <= mem_rdata_i[LEN_W-1:0];
                     last_q  <= mem_rdata_i[LAST_BIT];
                     wrap_q  <= mem_rdata_i[WRAP_BIT];
                     state_q <= (mem_rdata_i[LEN_W-1:0] != '0) ? S_LOAD : S_ADV;
                  end
               end
            end
            S_LOAD: begin
               if (mem_ack_i) begin
                  word_q <= mem_rdata_i;
                  if (mem_err_i) und_q <= 1'b1;
                  state_q <= S_EMIT;
               end
            end
            S_EMIT: begin
               if (tx_ready_i) begin
                  buf_q <= buf_q + AW'(1);
                  rem_q <= rem_q - ONE;
                  if (rem_q == ONE) begin
                     state_q <= S_ADV;
                  end else if (buf_q[1:0] == 2'b11) begin
                     state_q <= S_LOAD;
                  end
               end
            end
            S_ADV: begin
               desc_q  <= next_desc_i;
               state_q <= last_q ? S_RETIRE : S_FETCH0;
            end
            S_RETIRE: begin
               if (mem_ack_i) begin
                  in_frame_q <= 1'b0;
                  exh_q      <= 1'b0;
                  und_q      <= 1'b0;
                  halt_q     <= 1'b0;
                  state_q    <= halt_q ? S_IDLE : S_FETCH0;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/txd_fetch_engine.sv
module txd_fetch_engine
   import txd_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we_i,
   input  logic              cmd_start_i,
   input  logic              cmd_txen_i,
   input  logic              stat_clr_i,
   input  logic [AW-1:0]     qbase_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [AW-1:0]     mem_addr_o,
   output logic [WORD_W-1:0] mem_wdata_o,
   input  logic [WORD_W-1:0] mem_rdata_i,
   input  logic              mem_ack_i,
   input  logic              mem_err_i,
   output logic              tx_valid_o,
   output logic [7:0]        tx_data_o,
   output logic              tx_eof_o,
   input  logic              tx_ready_i,
   output logic              done_o,
   output logic              busy_o
);
   generate
      if (AW < 6 || AW > WORD_W) begin : g_aw_bad
         $error("txd_fetch_engine: AW must lie between 6 and 32");
      end
   endgenerate

   logic              go_w;
   logic [AW-1:0]     next_desc_w;
   logic [AW-1:0]     desc_addr_w;
   logic              wrap_w;
   logic [WORD_W-1:0] word_w;
   logic [1:0]        lane_w;
   logic              retire_w;

   assign go_w = cmd_we_i && cmd_start_i && cmd_txen_i;

   txd_seq #(.AW(AW)) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_i        (go_w),
      .qbase_i     (qbase_i),
      .next_desc_i (next_desc_w),
      .mem_ack_i   (mem_ack_i),
      .mem_rdata_i (mem_rdata_i),
      .mem_err_i   (mem_err_i),
      .tx_ready_i  (tx_ready_i),
      .mem_req_o   (mem_req_o),
      .mem_we_o    (mem_we_o),
      .mem_addr_o  (mem_addr_o),
      .mem_wdata_o (mem_wdata_o),
      .tx_valid_o  (tx_valid_o),
      .tx_eof_o    (tx_eof_o),
      .word_o      (word_w),
      .lane_o      (lane_w),
      .desc_addr_o (desc_addr_w),
      .wrap_o      (wrap_w),
      .busy_o      (busy_o),
      .retire_o    (retire_w)
   );

   txd_desc_step #(.AW(AW)) step_i (
      .cur_i  (desc_addr_w),
      .base_i (qbase_i),
      .wrap_i (wrap_w),
      .next_o (next_desc_w)
   );

   txd_lane_pick #(.DW(WORD_W)) pick_i (
      .word_i (word_w),
      .sel_i  (lane_w),
      .byte_o (tx_data_o)
   );

   txd_status stat_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (retire_w),
      .clr_i  (stat_clr_i),
      .done_o (done_o)
   );
endmodule

// File: rtl/txd_fetch_engine_chk.sv
module txd_fetch_engine_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          stat_clr_i,
   input logic          mem_req_o,
   input logic          mem_we_o,
   input logic [AW-1:0] mem_addr_o,
   input logic [31:0]   mem_wdata_o,
   input logic          mem_ack_i,
   input logic          tx_valid_o,
   input logic [7:0]    tx_data_o,
   input logic          tx_eof_o,
   input logic          tx_ready_i,
   input logic          done_o,
   input logic          busy_o
);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mem_req_o && !tx_valid_o));

   // R5
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=>
         (tx_valid_o && $stable(tx_data_o) && $stable(tx_eof_o)));

   // R6
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=>
         (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

   // R8
   wb_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> mem_wdata_o[31]);

   // R8
   done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(mem_req_o && mem_we_o && mem_ack_i));

   // R13
   done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr_i && !(mem_req_o && mem_we_o && mem_ack_i)) |=> !done_o);
endmodule

bind txd_fetch_engine txd_fetch_engine_chk #(.AW(AW)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .stat_clr_i  (stat_clr_i),
   .mem_req_o   (mem_req_o),
   .mem_we_o    (mem_we_o),
   .mem_addr_o  (mem_addr_o),
   .mem_wdata_o (mem_wdata_o),
   .mem_ack_i   (mem_ack_i),
   .tx_valid_o  (tx_valid_o),
   .tx_data_o   (tx_data_o),
   .tx_eof_o    (tx_eof_o),
   .tx_ready_i  (tx_ready_i),
   .done_o      (done_o),
   .busy_o      (busy_o)
);

// File: tb/txd_fetch_engine_tb_top.sv
`timescale 1ns/1ps
module txd_fetch_engine_tb_top;
   localparam int AW = 12;
   localparam int NW = 1024;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_we = 1'b0, cmd_start = 1'b0, cmd_txen = 1'b0, stat_clr = 1'b0;
   logic [AW-1:0] qbase = '0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata;
   logic [31:0]   mem_rdata = '0;
   logic          mem_ack = 1'b0, mem_err = 1'b0;
   logic          tx_valid, tx_eof;
   logic [7:0]    tx_data;
   logic          tx_ready = 1'b0;
   logic          done, busy;

   always #10 clk = ~clk;

   txd_fetch_engine #(.AW(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_we_i(cmd_we), .cmd_start_i(cmd_start),
      .cmd_txen_i(cmd_txen), .stat_clr_i(stat_clr), .qbase_i(qbase),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
      .mem_err_i(mem_err), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
      .tx_eof_o(tx_eof), .tx_ready_i(tx_ready), .done_o(done), .busy_o(busy)
   );

   int ntests = 0, nfail = 0;
   logic [31:0] mem [NW];
   int lat = 0, mode = 0, err_addr = -1, acnt = 0, req_cyc = 0, scyc = 0;
   int wr_n = 0, got_n = 0, eof_n = 0, exp_n = 0, xeof_n = 0;
   int wr_addr [16];
   logic [31:0] wr_dat [16];
   logic [7:0] got [512];
   logic [7:0] expb [512];
   int eofi [16];
   int xeofi [16];
   int wdog = 0;

   function automatic logic [7:0] pat(int a);
      return 8'((a * 29 + 11) ^ (a >> 8));
   endfunction

   function automatic logic [31:0] w1(int len, bit lastb, bit wrap, bit used);
      return (32'(len) & 32'h7FF) | (32'(lastb) << 15) | (32'(wrap) << 30) | (32'(used) << 31);
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      ntests++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // memory model: ack after lat idle negedges, one beat per request
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
         mem_err = 1'b0;
         acnt = 0;
      end else if (rst_n && mem_req) begin
         req_cyc++;
         if (acnt >= lat) begin
            mem_ack = 1'b1;
            if (mem_we) begin
               mem[int'(mem_addr) >> 2] = mem_wdata;
               if (wr_n < 16) begin
                  wr_addr[wr_n] = int'(mem_addr);
                  wr_dat[wr_n] = mem_wdata;
               end
               wr_n++;
            end else begin
               mem_rdata = mem[int'(mem_addr) >> 2];
               mem_err = (int'(mem_addr) == err_addr);
            end
         end else begin
            acnt++;
         end
      end
   end

   // sink and monitor
   always @(negedge clk) begin
      scyc++;
      case (mode)
         0: tx_ready = 1'b1;
         1: tx_ready = (scyc % 3) != 0;
         default: tx_ready = (scyc % 5) < 2;
      endcase
      if (rst_n && tx_valid && tx_ready) begin
         if (tx_eof && eof_n < 16) begin
            eofi[eof_n] = got_n;
            eof_n++;
         end
         if (got_n < 512) got[got_n] = tx_data;
         got_n++;
      end
   end

   always @(posedge clk) begin
      wdog++;
      if (wdog > 190000) begin
         nfail++;
         $display("FAIL WDOG: actual=%0d expected<%0d", wdog, 190000);
         $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
         $finish;
      end
   end

   task automatic fill_mem();
      for (int w = 0; w < NW; w++)
         mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
   endtask

   task automatic clear_logs();
      wr_n = 0; got_n = 0; eof_n = 0; exp_n = 0; xeof_n = 0; req_cyc = 0; err_addr = -1;
   endtask

   task automatic put_desc(int a, int bufa, logic [31:0] stat);
      mem[a >> 2] = 32'(bufa);
      mem[(a >> 2) + 1] = stat;
   endtask

   task automatic expect_buf(int b, int n, bit lastb);
      for (int i = 0; i < n; i++) begin
         expb[exp_n] = pat(b + i);
         exp_n++;
      end
      if (lastb && n > 0) begin
         xeofi[xeof_n] = exp_n - 1;
         xeof_n++;
      end
   endtask

   task automatic start_cmd(bit txen);
      @(negedge clk);
      cmd_we = 1'b1; cmd_start = 1'b1; cmd_txen = txen;
      @(negedge clk);
      cmd_we = 1'b0; cmd_start = 1'b0; cmd_txen = 1'b0;
   endtask

   task automatic wait_idle(string req);
      int t = 0;
      while (busy && t < 5000) begin
         @(negedge clk);
         t++;
      end
      check(!busy, req, busy, 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic cmp_stream(string req);
      int mism = 0;
      int emism = 0;
      check(got_n == exp_n, req, got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++)
         if (got[i] !== expb[i]) mism++;
      check(mism == 0, req, mism, 0);
      if (eof_n != xeof_n) emism++;
      for (int i = 0; i < xeof_n && i < eof_n; i++)
         if (eofi[i] != xeofi[i]) emism++;
      check(emism == 0, req, eof_n, xeof_n);
   endtask

   task automatic clear_done();
      @(negedge clk); stat_clr = 1'b1;
      @(negedge clk); stat_clr = 1'b0;
   endtask

   initial begin
      int b;
      fill_mem();
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy && !done && !mem_req && !tx_valid, "R1 reset",
            {busy, done, mem_req, tx_valid}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy && !done && !mem_req, "R1 after release", {busy, done, mem_req}, 0);

      // R2 start without transmit enable does nothing
      clear_logs();
      put_desc(0, 'h400, w1(4, 1, 0, 0));
      start_cmd(1'b0);
      repeat (20) @(negedge clk);
      check(req_cyc == 0 && !busy, "R2 no txen", req_cyc, 0);

      // sweep: single-buffer frame + terminating dummy (R2 R3 R4 R5 R6 R8 R9 R13)
      for (int l = 0; l < 3; l++)
         for (int m = 0; m < 3; m++)
            for (int off = 0; off < 4; off++)
               for (int len = 1; len <= 9; len++) begin
                  fill_mem(); clear_logs();
                  lat = l; mode = m;
                  qbase = (l % 2) ? 12'h100 : 12'h000;
                  b = 'h400 + 16 * len + off;
                  put_desc(int'(qbase), b, w1(len, 1, 0, 0));
                  put_desc(int'(qbase) + 8, 0, w1(0, 1, 1, 1));
                  expect_buf(b, len, 1);
                  start_cmd(1'b1);
                  wait_idle("R9 stop at dummy");
                  cmp_stream("R4 sweep bytes");
                  check(wr_n == 1, "R8 one writeback", wr_n, 1);
                  check(wr_addr[0] == int'(qbase) + 4, "R2 R8 wb addr", wr_addr[0], int'(qbase) + 4);
                  check(wr_dat[0] == (w1(len, 1, 0, 0) | 32'h8000_0000), "R8 wb data",
                        wr_dat[0], w1(len, 1, 0, 0) | 32'h8000_0000);
                  check(done, "R8 done set", done, 1);
                  repeat (4) @(negedge clk);
                  check(done, "R13 done sticky", done, 1);
                  clear_done();
                  check(!done, "R13 done cleared", done, 0);
               end

      // multi-buffer frame with unaligned and empty buffers (R3 R4 R7)
      fill_mem(); clear_logs(); lat = 1; mode = 1; qbase = 12'h040;
      put_desc('h040, 'h401, w1(3, 0, 0, 0));
      put_desc('h048, 'h500, w1(0, 0, 0, 0));
      put_desc('h050, 'h602, w1(6, 1, 0, 0));
      put_desc('h058, 0, w1(0, 1, 1, 1));
      expect_buf('h401, 3, 0); expect_buf('h602, 6, 1);
      start_cmd(1'b1); wait_idle("R7 multi stop");
      cmp_stream("R4 multi-buffer");
      check(wr_n == 1 && wr_addr[0] == 'h044, "R8 multi wb addr", wr_addr[0], 'h044);
      check(wr_dat[0] == (w1(3, 0, 0, 0) | 32'h8000_0000), "R8 multi wb data",
            wr_dat[0], w1(3, 0, 0, 0) | 32'h8000_0000);
      clear_done();

      // two frames in one chain (R8 continue)
      fill_mem(); clear_logs(); lat = 0; mode = 0; qbase = 12'h000;
      put_desc('h000, 'h700, w1(2, 1, 0, 0));
      put_desc('h008, 'h713, w1(3, 1, 0, 0));
      put_desc('h010, 0, w1(0, 1, 1, 1));
      expect_buf('h700, 2, 1); expect_buf('h713, 3, 1);
      start_cmd(1'b1); wait_idle("R8 two frames stop");
      cmp_stream("R8 two frames");
      check(wr_n == 2 && wr_addr[0] == 'h004 && wr_addr[1] == 'h00C, "R8 two wb",
            wr_addr[1], 'h00C);
      clear_done();

      // wrap back to base, which now holds a returned descriptor (R7 R9)
      fill_mem(); clear_logs(); lat = 2; mode = 2; qbase = 12'h100;
      put_desc('h100, 'h500, w1(3, 1, 0, 0));
      put_desc('h108, 'h600, w1(2, 1, 1, 0));
      put_desc('h110, 'h700, w1(4, 1, 0, 0));
      expect_buf('h500, 3, 1); expect_buf('h600, 2, 1);
      start_cmd(1'b1); wait_idle("R7 wrap stop");
      cmp_stream("R7 wrap no decoy");
      check(wr_n == 2 && wr_addr[1] == 'h10C, "R7 wrap wb", wr_n, 2);
      clear_done();

      // used descriptor at frame start (R9)
      fill_mem(); clear_logs(); lat = 0; mode = 0; qbase = 12'h000;
      put_desc('h000, 'h500, w1(5, 1, 0, 1));
      start_cmd(1'b1); wait_idle("R9 used first");
      check(got_n == 0 && wr_n == 0, "R9 nothing sent", got_n + wr_n, 0);
      check(!done, "R9 done unchanged", done, 0);

      // exhaustion inside a frame (R10)
      fill_mem(); clear_logs(); lat = 1; mode = 0;
      put_desc('h000, 'h500, w1(4, 0, 0, 0));
      put_desc('h008, 'h600, w1(4, 1, 0, 1));
      expect_buf('h500, 4, 0);
      start_cmd(1'b1); wait_idle("R10 exhausted stop");
      cmp_stream("R10 bytes before exhaustion");
      check(wr_n == 1 && wr_addr[0] == 'h004, "R10 wb addr", wr_addr[0], 'h004);
      check(wr_dat[0] == (w1(4, 0, 0, 0) | 32'h8800_0000), "R10 wb data",
            wr_dat[0], w1(4, 0, 0, 0) | 32'h8800_0000);
      check(done, "R10 done", done, 1);
      clear_done();

      // read error on buffer data (R11)
      fill_mem(); clear_logs(); lat = 0; mode = 1;
      put_desc('h000, 'h800, w1(8, 1, 0, 0));
      put_desc('h008, 0, w1(0, 1, 1, 1));
      expect_buf('h800, 8, 1);
      err_addr = 'h804;
      start_cmd(1'b1); wait_idle("R11 stop");
      cmp_stream("R11 bytes");
      check(wr_dat[0] == (w1(8, 1, 0, 0) | 32'h9000_0000), "R11 underrun flag",
            wr_dat[0], w1(8, 1, 0, 0) | 32'h9000_0000);
      clear_done();

      // start while busy ignored (R12)
      fill_mem(); clear_logs(); lat = 1; mode = 1;
      put_desc('h000, 'h900, w1(40, 1, 0, 0));
      put_desc('h008, 0, w1(0, 1, 1, 1));
      expect_buf('h900, 40, 1);
      start_cmd(1'b1);
      repeat (30) @(negedge clk);
      check(busy, "R12 still busy", busy, 1);
      start_cmd(1'b1);
      wait_idle("R12 stop");
      cmp_stream("R12 stream unchanged");
      check(wr_n == 1, "R12 single writeback", wr_n, 1);

      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end
endmodule